// File: doc/BRIEF.md
# Trap Entry Sequencer

This block computes the architectural state changes made when a hart takes an exception or an interrupt. When the take strobe is high, it samples the trap kind (interrupt or synchronous exception), the raw cause code, the current privilege, the program counter, the faulting address, both delegation masks, the status word and the two trap vector bases. It picks the handling level, supervisor or machine, and returns everything in one cycle. The outputs are the new status word, the new PC and the new privilege, plus one write strobe for the chosen level together with the cause, exception-PC and trap-value words to write.

Delegation is honoured only when the hart runs at user or supervisor level. A synchronous environment call is entered as a single cause and renumbered here by the privilege it came from. Vectored dispatch applies to interrupts only. The trap value carries the faulting address only for address-related faults.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is asserted, `priv_o` is machine level (3), `pc_o` is the `RESET_PC` parameter, `status_o` is zero and both write strobes are low.
- R2: One cycle after a take, exactly one strobe is high. `sup_wr_o` is high when the current privilege is 0 or 1, the effective cause code is below XLEN, and bit [cause] of the delegation mask is set. That mask is `ideleg_i` for interrupts and `edeleg_i` otherwise. In every other case `mach_wr_o` is high.
- R3: On supervisor entry, status bit 5 takes the old bit 1, bit 8 takes the old privilege bit 0, bit 1 is cleared, the privilege becomes 1, and all other status bits keep their values.
- R4: On machine entry, status bit 7 takes the old bit 3, bits 12:11 take the old privilege, bit 3 is cleared, the privilege becomes 3, and all other status bits keep their values.
- R5: `cause_o` is the effective cause code, zero-extended, with bit XLEN-1 set for interrupts and clear for exceptions.
- R6: A synchronous cause 8 (environment call) becomes 8 plus the current privilege: 8, 9 or 11. The renumbered value is used for both delegation and the cause word. An interrupt with code 8 is not renumbered.
- R7: `epc_o` is the PC presented with the take.
- R8: The new PC is the chosen vector base with bits 1:0 cleared. When the trap is an interrupt and the base's bits 1:0 equal 1, four times the cause code is added.
- R9: `tval_o` is `badaddr_i` for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15, and zero for every other cause and for all interrupts.
- R10: In a cycle after one with no take, both strobes are low and `pc_o`, `priv_o` and `status_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Take the trap described by the other inputs |
| async_i | input | 1 | 1 for interrupt, 0 for exception |
| cause_i | input | CAUSE_W | Raw cause code |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| pc_i | input | XLEN | PC of the trapping point |
| badaddr_i | input | XLEN | Faulting address |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| edeleg_i | input | XLEN | Exception delegation mask |
| status_i | input | XLEN | Current status word |
| stvec_i | input | XLEN | Supervisor vector base and mode |
| mtvec_i | input | XLEN | Machine vector base and mode |
| sup_wr_o | output | 1 | Write supervisor trap registers |
| mach_wr_o | output | 1 | Write machine trap registers |
| cause_o | output | XLEN | Cause word to write |
| epc_o | output | XLEN | Exception PC to write |
| tval_o | output | XLEN | Trap value to write |
| status_o | output | XLEN | New status word |
| pc_o | output | XLEN | New PC |
| priv_o | output | 2 | New privilege |

## Verification
The properties assume that the privilege input never carries the reserved value 2 and that an environment call arrives only as a synchronous cause 8. They also assume the cause code is narrower than XLEN, so a cause code of XLEN or more simply falls back to machine handling. The random stimulus draws the privilege only from 0, 1 and 3. It draws cause codes from the standard range and sometimes from values at or above XLEN for interrupts. Delegation masks, status words and vector bases with all four mode encodings are drawn at random. Directed cases cover vectored interrupts, cause codes beyond XLEN, machine-level traps under full delegation, and environment calls from each level.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
   // status word bit positions decoded by neighbouring logic
   localparam int ST_SIE    = 1;
   localparam int ST_MIE    = 3;
   localparam int ST_SPIE   = 5;
   localparam int ST_MPIE   = 7;
   localparam int ST_SPP    = 8;
   localparam int ST_MPP_LO = 11;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int unsigned CODE_ECALL_U = 8;

   // synchronous causes whose trap value is the faulting address
   function automatic logic carries_addr(input int unsigned code);
      case (code)
         0, 1, 4, 5, 6, 7, 12, 13, 15: return 1'b1;
         default:                      return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/trap_seq_route.sv
module trap_seq_route
   import trap_seq_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 6
) (
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [1:0]         priv_i,
   input  logic [XLEN-1:0]    ideleg_i,
   input  logic [XLEN-1:0]    edeleg_i,
   output logic [CAUSE_W-1:0] code_o,
   output logic               to_sup_o
);
   localparam int IDX_W = $clog2(XLEN);
   localparam logic [CAUSE_W:0] LIMIT = (CAUSE_W+1)'(XLEN);

   logic [XLEN-1:0] mask;
   logic            in_range;

   always_comb begin
      code_o = cause_i;
      if (!async_i && cause_i == CAUSE_W'(CODE_ECALL_U))
         code_o = cause_i + {{(CAUSE_W-2){1'b0}}, priv_i};
   end

   assign mask     = async_i ? ideleg_i : edeleg_i;
   assign in_range = {1'b0, code_o} < LIMIT;
   assign to_sup_o = !priv_i[1] && in_range && mask[code_o[IDX_W-1:0]];
endmodule

// File: rtl/trap_seq_status.sv
module trap_seq_status
   import trap_seq_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] status_i,
   input  logic [1:0]      priv_i,
   input  logic            to_sup_i,
   output logic [XLEN-1:0] status_o,
   output logic [1:0]      priv_o
);
   always_comb begin
      status_o = status_i;
      if (to_sup_i) begin
         status_o[ST_SPIE] = status_i[ST_SIE];
         status_o[ST_SPP]  = priv_i[0];
         status_o[ST_SIE]  = 1'b0;
         priv_o            = PRIV_S;
      end else begin
         status_o[ST_MPIE]                = status_i[ST_MIE];
         status_o[ST_MPP_LO+1:ST_MPP_LO]  = priv_i;
         status_o[ST_MIE]                 = 1'b0;
         priv_o                           = PRIV_M;
      end
   end
endmodule

// File: rtl/trap_seq_target.sv
module trap_seq_target
   import trap_seq_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CAUSE_W   = 6,
   parameter bit VECTOR_EN = 1'b1
) (
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] code_i,
   input  logic               to_sup_i,
   input  logic [XLEN-1:0]    stvec_i,
   input  logic [XLEN-1:0]    mtvec_i,
   input  logic [XLEN-1:0]    badaddr_i,
   output logic [XLEN-1:0]    pc_o,
   output logic [XLEN-1:0]    tval_o
);
   localparam logic [1:0] MODE_VECTORED = 2'b01;

   logic [XLEN-1:0] tvec;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   assign tvec = to_sup_i ? stvec_i : mtvec_i;
   assign base = {tvec[XLEN-1:2], 2'b00};

   generate
      if (VECTOR_EN) begin : g_vectored
         assign offset = (async_i && tvec[1:0] == MODE_VECTORED)
                       ? ({{(XLEN-CAUSE_W){1'b0}}, code_i} << 2) : '0;
      end else begin : g_direct
         assign offset = '0;
      end
   endgenerate

   assign pc_o   = base + offset;
   assign tval_o = (!async_i && carries_addr(32'(code_i))) ? badaddr_i : '0;
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_seq_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          CAUSE_W   = 6,
   parameter bit          VECTOR_EN = 1'b1,
   parameter int unsigned RESET_PC  = 32'h0000_1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [1:0]         priv_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [XLEN-1:0]    badaddr_i,
   input  logic [XLEN-1:0]    ideleg_i,
   input  logic [XLEN-1:0]    edeleg_i,
   input  logic [XLEN-1:0]    status_i,
   input  logic [XLEN-1:0]    stvec_i,
   input  logic [XLEN-1:0]    mtvec_i,
   output logic               sup_wr_o,
   output logic               mach_wr_o,
   output logic [XLEN-1:0]    cause_o,
   output logic [XLEN-1:0]    epc_o,
   output logic [XLEN-1:0]    tval_o,
   output logic [XLEN-1:0]    status_o,
   output logic [XLEN-1:0]    pc_o,
   output logic [1:0]         priv_o
);
   localparam int IDX_W = $clog2(XLEN);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trap_entry_seq: XLEN must be 32 or 64");
      end
      if (CAUSE_W <= IDX_W || CAUSE_W >= XLEN) begin : g_bad_cause_w
         $error("trap_entry_seq: CAUSE_W must exceed log2(XLEN) and be below XLEN");
      end
   endgenerate

   logic [CAUSE_W-1:0] code;
   logic               to_sup;
   logic [XLEN-1:0]    status_n;
   logic [1:0]         priv_n;
   logic [XLEN-1:0]    pc_n;
   logic [XLEN-1:0]    tval_n;
   logic [XLEN-1:0]    cause_n;

   trap_seq_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) route_i (
      .async_i  (async_i),
      .cause_i  (cause_i),
      .priv_i   (priv_i),
      .ideleg_i (ideleg_i),
      .edeleg_i (edeleg_i),
      .code_o   (code),
      .to_sup_o (to_sup)
   );

   trap_seq_status #(.XLEN(XLEN)) status_i_u (
      .status_i (status_i),
      .priv_i   (priv_i),
      .to_sup_i (to_sup),
      .status_o (status_n),
      .priv_o   (priv_n)
   );

   trap_seq_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTOR_EN(VECTOR_EN)) target_i (
      .async_i   (async_i),
      .code_i    (code),
      .to_sup_i  (to_sup),
      .stvec_i   (stvec_i),
      .mtvec_i   (mtvec_i),
      .badaddr_i (badaddr_i),
      .pc_o      (pc_n),
      .tval_o    (tval_n)
   );

   assign cause_n = {async_i, {(XLEN-1-CAUSE_W){1'b0}}, code};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_wr_o  <= 1'b0;
         mach_wr_o <= 1'b0;
         cause_o   <= '0;
         epc_o     <= '0;
         tval_o    <= '0;
         status_o  <= '0;
         pc_o      <= XLEN'(RESET_PC);
         priv_o    <= PRIV_M;
      end else begin
         sup_wr_o  <= take_i && to_sup;
         mach_wr_o <= take_i && !to_sup;
         if (take_i) begin
            cause_o  <= cause_n;
            epc_o    <= pc_i;
            tval_o   <= tval_n;
            status_o <= status_n;
            pc_o     <= pc_n;
            priv_o   <= priv_n;
         end
      end
   end
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               take_i,
   input logic               async_i,
   input logic [1:0]         priv_i,
   input logic [XLEN-1:0]    pc_i,
   input logic               sup_wr_o,
   input logic               mach_wr_o,
   input logic [XLEN-1:0]    cause_o,
   input logic [XLEN-1:0]    epc_o,
   input logic [XLEN-1:0]    tval_o,
   input logic [XLEN-1:0]    status_o,
   input logic [XLEN-1:0]    pc_o,
   input logic [1:0]         priv_o
);
   // R2
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sup_wr_o, mach_wr_o}));
   // R2
   take_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (sup_wr_o || mach_wr_o));
   // R2
   mach_priv_keeps_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && priv_i == 2'd3) |=> mach_wr_o);
   // R3
   sup_entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sup_wr_o |-> (priv_o == 2'd1 && !status_o[1]));
   // R4
   mach_entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mach_wr_o |-> (priv_o == 2'd3 && !status_o[3]));
   // R5
   cause_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (cause_o[XLEN-1] == $past(async_i)));
   // R7
   epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (epc_o == $past(pc_i)));
   // R8
   pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (pc_o[1:0] == 2'b00));
   // R9
   irq_tval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && async_i) |=> (tval_o == '0));
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> (!sup_wr_o && !mach_wr_o && $stable(pc_o) && $stable(priv_o)
                   && $stable(status_o)));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .take_i    (take_i),
   .async_i   (async_i),
   .priv_i    (priv_i),
   .pc_i      (pc_i),
   .sup_wr_o  (sup_wr_o),
   .mach_wr_o (mach_wr_o),
   .cause_o   (cause_o),
   .epc_o     (epc_o),
   .tval_o    (tval_o),
   .status_o  (status_o),
   .pc_o      (pc_o),
   .priv_o    (priv_o)
);

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 32;
   localparam int CAUSE_W    = 6;
   localparam logic [31:0] RST_PC = 32'h0000_1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              take_i = 1'b0;
   logic              async_i = 1'b0;
   logic [CAUSE_W-1:0] cause_i = '0;
   logic [1:0]        priv_i = 2'd3;
   logic [XLEN-1:0]   pc_i = '0, badaddr_i = '0, ideleg_i = '0, edeleg_i = '0;
   logic [XLEN-1:0]   status_i = '0, stvec_i = '0, mtvec_i = '0;
   logic              sup_wr_o, mach_wr_o;
   logic [XLEN-1:0]   cause_o, epc_o, tval_o, status_o, pc_o;
   logic [1:0]        priv_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [XLEN-1:0] hold_pc, hold_status;
   logic [1:0]      hold_priv;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_entry_seq #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .RESET_PC(RST_PC)) dut_i (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .async_i(async_i), .cause_i(cause_i),
      .priv_i(priv_i), .pc_i(pc_i), .badaddr_i(badaddr_i), .ideleg_i(ideleg_i),
      .edeleg_i(edeleg_i), .status_i(status_i), .stvec_i(stvec_i), .mtvec_i(mtvec_i),
      .sup_wr_o(sup_wr_o), .mach_wr_o(mach_wr_o), .cause_o(cause_o), .epc_o(epc_o),
      .tval_o(tval_o), .status_o(status_o), .pc_o(pc_o), .priv_o(priv_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit addr_fault(input int unsigned c);
      return c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
             c == 12 || c == 13 || c == 15;
   endfunction

   task automatic fire(input bit as, input int unsigned c, input logic [1:0] pv,
                       input logic [31:0] pc, input logic [31:0] ba,
                       input logic [31:0] idl, input logic [31:0] edl,
                       input logic [31:0] st, input logic [31:0] stv,
                       input logic [31:0] mtv, input bit tk);
      int unsigned code;
      logic [31:0] msk, vec, e_st, e_pc, e_cause, e_tval;
      bit sup;
      logic [1:0] e_priv;
      async_i = as; cause_i = CAUSE_W'(c); priv_i = pv; pc_i = pc; badaddr_i = ba;
      ideleg_i = idl; edeleg_i = edl; status_i = st; stvec_i = stv; mtvec_i = mtv;
      take_i = tk;
      code = c;
      if (!as && c == 8) code = 8 + pv;
      msk = as ? idl : edl;
      sup = (pv == 2'd0 || pv == 2'd1) && code < 32 && msk[code % 32];
      e_st = st;
      if (sup) begin
         e_st[5] = st[1]; e_st[8] = pv[0]; e_st[1] = 1'b0; e_priv = 2'd1; vec = stv;
      end else begin
         e_st[7] = st[3]; e_st[12:11] = pv; e_st[3] = 1'b0; e_priv = 2'd3; vec = mtv;
      end
      e_pc = {vec[31:2], 2'b00};
      if (as && vec[1:0] == 2'b01) e_pc = e_pc + code * 4;
      e_cause = {as, 31'(code)};
      e_tval = (!as && addr_fault(code)) ? ba : 32'h0;
      @(posedge clk);
      #1;
      if (tk) begin
         check("R2 sup strobe", 64'(sup_wr_o), 64'(sup));
         check("R2 mach strobe", 64'(mach_wr_o), 64'(!sup));
         check(sup ? "R3 status" : "R4 status", 64'(status_o), 64'(e_st));
         check(sup ? "R3 priv" : "R4 priv", 64'(priv_o), 64'(e_priv));
         check((!as && c == 8) ? "R6 cause" : "R5 cause", 64'(cause_o), 64'(e_cause));
         check("R7 epc", 64'(epc_o), 64'(pc));
         check("R8 pc", 64'(pc_o), 64'(e_pc));
         check("R9 tval", 64'(tval_o), 64'(e_tval));
         hold_pc = e_pc; hold_status = e_st; hold_priv = e_priv;
      end else begin
         check("R10 strobes", 64'({sup_wr_o, mach_wr_o}), 64'(0));
         check("R10 pc", 64'(pc_o), 64'(hold_pc));
         check("R10 priv", 64'(priv_o), 64'(hold_priv));
         check("R10 status", 64'(status_o), 64'(hold_status));
      end
      take_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [1:0] privs [3];
      privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      check("R1 priv", 64'(priv_o), 64'(3));
      check("R1 pc", 64'(pc_o), 64'(RST_PC));
      check("R1 status", 64'(status_o), 64'(0));
      check("R1 strobes", 64'({sup_wr_o, mach_wr_o}), 64'(0));
      hold_pc = RST_PC; hold_status = '0; hold_priv = 2'd3;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 idle right after reset
      fire(1'b0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
      // R8 vectored interrupt into S: base 0x200, cause 5 -> 0x214
      fire(1'b1, 5, 2'd0, 32'h80, 32'h55, 32'h20, 0, 32'h2, 32'h201, 32'h301, 1'b1);
      // R8 vectored mode on exception adds nothing
      fire(1'b0, 2, 2'd1, 32'h84, 32'h55, 0, 32'h4, 32'h2, 32'h201, 32'h301, 1'b1);
      // R2 cause beyond XLEN never delegates
      fire(1'b1, 40, 2'd0, 32'h88, 0, 32'hFFFF_FFFF, 0, 32'h8, 0, 32'h401, 1'b1);
      // R2 machine level ignores full delegation
      fire(1'b0, 13, 2'd3, 32'h8C, 32'hDEAD_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
           32'hA, 32'h500, 32'h600, 1'b1);
      // R6 ecall from U, S, M with delegation of 8 and 9
      fire(1'b0, 8, 2'd0, 32'h90, 32'h1, 0, 32'h300, 32'h2, 32'h700, 32'h800, 1'b1);
      fire(1'b0, 8, 2'd1, 32'h94, 32'h1, 0, 32'h300, 32'h2, 32'h700, 32'h800, 1'b1);
      fire(1'b0, 8, 2'd3, 32'h98, 32'h1, 0, 32'hFFFF_FFFF, 32'h8, 32'h700, 32'h800, 1'b1);
      // R6 interrupt code 8 is not renumbered
      fire(1'b1, 8, 2'd1, 32'h9C, 32'h1, 0, 32'h200, 32'h8, 32'h700, 32'h801, 1'b1);
      for (int i = 0; i < 600; i++) begin
         bit as;
         int unsigned c;
         as = ($urandom_range(0, 1) == 1);
         c = $urandom_range(0, 15);
         if (as && $urandom_range(0, 9) == 0) c = 32 + $urandom_range(0, 31);
         fire(as, c, privs[$urandom_range(0, 2)], $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom, ($urandom_range(0, 5) != 0));
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule